// File: doc/BRIEF.md
# Parallel NOR Flash Command Sequencer

This block sits between a host and an asynchronous parallel NOR flash device and turns one host request into the full series of bus cycles that the device's unlock-based command protocol expects. The host picks one of six operations (return to read mode, fetch the maker code, fetch the part code, program one word, erase one sector, erase the whole array). It supplies a target address and data word where the operation needs them, and then waits for a one-cycle completion pulse that comes with a two-bit result code.

After the command writes, program and erase operations poll the device. Bit 7 of the status read tells whether the operation has completed. Bit 5 flags an internal time limit and triggers exactly one confirming re-read. Bit 3 ends a whole-array erase early. A failed confirmation makes the block send the return-to-read sequence before it reports the failure. A host-visible poll limit turns a device that never finishes into a timeout result. Every bus cycle has a setup phase, a strobe phase and a hold phase, each a fixed number of clocks.

Top module: `nor_cmd_sequencer`

## Requirements
- R1: Every accepted operation starts with two unlock writes: data 0xAA at command offset 0x5555, then data 0x55 at command offset 0xAAAA. A command offset is placed on the address bus shifted left by one when `wide_bus` is 1 (byte address 0x0AAAA and 0x15554).
- R2: Program (op code 3) writes 0xA0 at offset 0x5555 and then the host data at the host address. It then reads that address until bit 7 of the read equals bit 7 of the host data, and finishes with result 0.
- R3: Sector erase (op code 4) writes 0x80 at 0x5555, a second pair of unlock writes, and 0x30 at the host address. It then polls the host address until bit 7 reads 1, and finishes with result 0.
- R4: Whole-array erase (op code 5) uses the same six writes, except that the last one is 0x10 at offset 0x5555. Its polls read address 0.
- R5: Return-to-read (op code 0) is the two unlock writes and 0xF0 at 0x5555, with no reads, and finishes with result 0.
- R6: Maker code (op code 1) and part code (op code 2) write 0x90 at 0x5555 and make one read at command offset 0 or 1 (scaled as in R1). They then send the return-to-read sequence, and `id_data` holds the word that was read.
- R7: A poll read that is not complete but has bit 5 set is followed by exactly one re-read. If the re-read shows completion, the result is 0 and no further cycles occur.
- R8: If the re-read is still not complete, the block writes the three-cycle return-to-read sequence and reports result 1 for program or 2 for either erase.
- R9: During a whole-array erase, a poll that is not complete with bit 3 set ends the operation with result 2, and no further writes follow.
- R10: After MAX_POLLS poll reads that are incomplete and have bits 5 and 3 clear, the operation ends with result 3 and no further writes follow.
- R11: A write or read strobe (active low) stays low for exactly STROBE_CLKS clocks. The two strobes are never low together. Address and write data do not change while a strobe is low.
- R12: `busy` rises in the clock after a request is accepted and falls in the clock after the single-cycle `done` pulse. Requests made while busy, and requests with op codes 6 or 7, are ignored and cause no bus cycles.
- R13: With `wide_bus` at 0, command offsets go on the bus unshifted (0x05555, 0x0AAAA, and 1 for the part code).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wide_bus | input | 1 | 1: 16-bit device, command offsets shifted left by one |
| req_valid | input | 1 | Request strobe, taken only when idle |
| req_op | input | 3 | Operation code 0..5 |
| req_addr | input | ADDR_W | Target bus address for program or sector erase |
| req_data | input | DATA_W | Word to program |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| err_code | output | 2 | 0 ok, 1 write failure, 2 erase failure, 3 timeout |
| id_data | output | DATA_W | Last identification word read |
| flash_addr | output | ADDR_W | Device address bus |
| flash_wdata | output | DATA_W | Device write data |
| flash_rdata | input | DATA_W | Device read data |
| flash_we_n | output | 1 | Write strobe, active low |
| flash_oe_n | output | 1 | Read strobe, active low |

## Verification
The bench builds the block with a one-clock setup, a two-clock strobe, a one-clock hold and a poll limit of 8. The short limit makes the timeout path reachable in a few hundred clocks, and the two-clock strobe makes a strobe-width error visible. A behavioural device model logs every write and read address and returns a scripted status word for each read. This lets the bench reach bit-5 recovery, a failed re-read, bit-3 termination and a poll that never ends, all with exact bus-cycle counts. Both settings of `wide_bus` are exercised.

// File: rtl/nor_cmd_pkg.sv
package nor_cmd_pkg;

  typedef enum logic [2:0] {
    OP_RESET      = 3'd0,
    OP_MFR_ID     = 3'd1,
    OP_PART_ID    = 3'd2,
    OP_PROGRAM    = 3'd3,
    OP_SECT_ERASE = 3'd4,
    OP_CHIP_ERASE = 3'd5
  } op_e;

  typedef enum logic [1:0] {
    K_WRITE = 2'd0,
    K_READ  = 2'd1,
    K_END   = 2'd2
  } kind_e;

  localparam logic [2:0]  OP_LAST     = 3'd5;

  localparam logic [1:0]  RES_OK      = 2'd0;
  localparam logic [1:0]  RES_WRITE   = 2'd1;
  localparam logic [1:0]  RES_ERASE   = 2'd2;
  localparam logic [1:0]  RES_TIMEOUT = 2'd3;

  localparam logic [15:0] OFS_KEY_A   = 16'h5555;
  localparam logic [15:0] OFS_KEY_B   = 16'hAAAA;

  localparam logic [7:0]  KEY_A       = 8'hAA;
  localparam logic [7:0]  KEY_B       = 8'h55;
  localparam logic [7:0]  C_EXIT      = 8'hF0;
  localparam logic [7:0]  C_IDENT     = 8'h90;
  localparam logic [7:0]  C_PROG      = 8'hA0;
  localparam logic [7:0]  C_ERASE     = 8'h80;
  localparam logic [7:0]  C_SECT      = 8'h30;
  localparam logic [7:0]  C_CHIP      = 8'h10;

endpackage

// File: rtl/nor_cmd_table.sv
module nor_cmd_table
  import nor_cmd_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int DATA_W = 16
) (
  input  op_e               op,
  input  logic [2:0]        step,
  input  logic              wide,
  input  logic [ADDR_W-1:0] tgt_addr,
  input  logic [DATA_W-1:0] tgt_data,
  output kind_e             kind,
  output logic [ADDR_W-1:0] addr,
  output logic [DATA_W-1:0] data
);

  function automatic logic [ADDR_W-1:0] scale(input logic [15:0] ofs, input logic w);
    logic [ADDR_W-1:0] a;
    a = ADDR_W'(ofs);
    return w ? (a << 1) : a;
  endfunction

  logic [7:0] setup_byte;
  logic       is_id;
  logic       is_erase;

  always_comb begin
    unique case (op)
      OP_MFR_ID, OP_PART_ID:        setup_byte = C_IDENT;
      OP_PROGRAM:                   setup_byte = C_PROG;
      OP_SECT_ERASE, OP_CHIP_ERASE: setup_byte = C_ERASE;
      default:                      setup_byte = C_EXIT;
    endcase
  end

  assign is_id    = (op == OP_MFR_ID) || (op == OP_PART_ID);
  assign is_erase = (op == OP_SECT_ERASE) || (op == OP_CHIP_ERASE);

  always_comb begin
    kind = K_END;
    addr = '0;
    data = '0;
    unique case (step)
      3'd0: begin kind = K_WRITE; addr = scale(OFS_KEY_A, wide); data = DATA_W'(KEY_A); end
      3'd1: begin kind = K_WRITE; addr = scale(OFS_KEY_B, wide); data = DATA_W'(KEY_B); end
      3'd2: begin kind = K_WRITE; addr = scale(OFS_KEY_A, wide); data = DATA_W'(setup_byte); end
      3'd3: begin
        if (is_id) begin
          kind = K_READ;
          addr = scale((op == OP_PART_ID) ? 16'h0001 : 16'h0000, wide);
        end else if (op == OP_PROGRAM) begin
          kind = K_WRITE; addr = tgt_addr; data = tgt_data;
        end else if (is_erase) begin
          kind = K_WRITE; addr = scale(OFS_KEY_A, wide); data = DATA_W'(KEY_A);
        end
      end
      3'd4: begin
        if (is_id) begin
          kind = K_WRITE; addr = scale(OFS_KEY_A, wide); data = DATA_W'(KEY_A);
        end else if (is_erase) begin
          kind = K_WRITE; addr = scale(OFS_KEY_B, wide); data = DATA_W'(KEY_B);
        end
      end
      3'd5: begin
        if (is_id) begin
          kind = K_WRITE; addr = scale(OFS_KEY_B, wide); data = DATA_W'(KEY_B);
        end else if (op == OP_SECT_ERASE) begin
          kind = K_WRITE; addr = tgt_addr; data = DATA_W'(C_SECT);
        end else if (op == OP_CHIP_ERASE) begin
          kind = K_WRITE; addr = scale(OFS_KEY_A, wide); data = DATA_W'(C_CHIP);
        end
      end
      3'd6: begin
        if (is_id) begin
          kind = K_WRITE; addr = scale(OFS_KEY_A, wide); data = DATA_W'(C_EXIT);
        end
      end
      default: kind = K_END;
    endcase
  end

endmodule

// File: rtl/nor_bus_cycle.sv
module nor_bus_cycle #(
  parameter int ADDR_W      = 20,
  parameter int DATA_W      = 16,
  parameter int SETUP_CLKS  = 2,
  parameter int STROBE_CLKS = 3,
  parameter int HOLD_CLKS   = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              rd,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [DATA_W-1:0] bus_wdata,
  input  logic [DATA_W-1:0] bus_rdata,
  output logic              we_n,
  output logic              oe_n,
  output logic [DATA_W-1:0] rdata,
  output logic              cyc_done
);

  localparam int MAX_A = (SETUP_CLKS > STROBE_CLKS) ? SETUP_CLKS : STROBE_CLKS;
  localparam int MAX_C = (MAX_A > HOLD_CLKS) ? MAX_A : HOLD_CLKS;
  localparam int CW    = $clog2(MAX_C + 1);

  typedef enum logic [1:0] {B_IDLE, B_SETUP, B_STROBE, B_HOLD} bstate_e;

  bstate_e           st_q, st_d;
  logic [CW-1:0]     cnt_q, cnt_d;
  logic              rd_q, rd_d;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q, rdata_q;
  logic              load, capture;
  logic              last_setup, last_strobe, last_hold;

  assign last_setup  = (cnt_q == CW'(SETUP_CLKS - 1));
  assign last_strobe = (cnt_q == CW'(STROBE_CLKS - 1));
  assign last_hold   = (cnt_q == CW'(HOLD_CLKS - 1));

  always_comb begin
    st_d    = st_q;
    cnt_d   = cnt_q + CW'(1);
    rd_d    = rd_q;
    load    = 1'b0;
    capture = 1'b0;
    unique case (st_q)
      B_IDLE: begin
        cnt_d = '0;
        if (start) begin
          st_d = B_SETUP;
          rd_d = rd;
          load = 1'b1;
        end
      end
      B_SETUP:  if (last_setup)  begin st_d = B_STROBE; cnt_d = '0; end
      B_STROBE: if (last_strobe) begin st_d = B_HOLD; cnt_d = '0; capture = rd_q; end
      B_HOLD:   if (last_hold)   begin st_d = B_IDLE; cnt_d = '0; end
      default:  st_d = B_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= B_IDLE;
      cnt_q   <= '0;
      rd_q    <= 1'b0;
      we_n    <= 1'b1;
      oe_n    <= 1'b1;
      addr_q  <= '0;
      wdata_q <= '0;
      rdata_q <= '0;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
      rd_q  <= rd_d;
      we_n  <= !((st_d == B_STROBE) && !rd_d);
      oe_n  <= !((st_d == B_STROBE) && rd_d);
      if (load) begin
        addr_q  <= addr;
        wdata_q <= wdata;
      end
      if (capture) rdata_q <= bus_rdata;
    end
  end

  assign bus_addr  = addr_q;
  assign bus_wdata = wdata_q;
  assign rdata     = rdata_q;
  assign cyc_done  = (st_q == B_HOLD) && last_hold;

endmodule

// File: rtl/nor_cmd_sequencer.sv
module nor_cmd_sequencer
  import nor_cmd_pkg::*;
#(
  parameter int ADDR_W      = 20,
  parameter int DATA_W      = 16,
  parameter int SETUP_CLKS  = 2,
  parameter int STROBE_CLKS = 3,
  parameter int HOLD_CLKS   = 2,
  parameter int MAX_POLLS   = 1024
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wide_bus,
  input  logic              req_valid,
  input  logic [2:0]        req_op,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_data,
  output logic              busy,
  output logic              done,
  output logic [1:0]        err_code,
  output logic [DATA_W-1:0] id_data,
  output logic [ADDR_W-1:0] flash_addr,
  output logic [DATA_W-1:0] flash_wdata,
  input  logic [DATA_W-1:0] flash_rdata,
  output logic              flash_we_n,
  output logic              flash_oe_n
);

  localparam int PCW = $clog2(MAX_POLLS + 1);

  typedef enum logic [2:0] {
    T_IDLE, T_ISSUE, T_WAIT, T_PGO, T_PWAIT, T_RGO, T_RWAIT, T_FIN
  } tstate_e;

  tstate_e           st_q, st_d;
  op_e               op_q, op_d, eff_op;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic [DATA_W-1:0] data_q, data_d, id_q, id_d;
  logic              wide_q, wide_d, recov_q, recov_d;
  logic [2:0]        step_q, step_d;
  logic [PCW-1:0]    pcnt_q, pcnt_d;
  logic [1:0]        err_q, err_d;

  kind_e             t_kind;
  logic [ADDR_W-1:0] t_addr, poll_addr, cyc_addr;
  logic [DATA_W-1:0] t_data, cyc_wdata, cyc_rdata;
  logic              cyc_start, cyc_rd, cyc_done, complete;

  assign eff_op    = recov_q ? OP_RESET : op_q;
  assign poll_addr = (op_q == OP_CHIP_ERASE) ? '0 : addr_q;
  assign complete  = (op_q == OP_PROGRAM) ? (cyc_rdata[7] == data_q[7]) : cyc_rdata[7];

  nor_cmd_table #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_table (
    .op       (eff_op),
    .step     (step_q),
    .wide     (wide_q),
    .tgt_addr (addr_q),
    .tgt_data (data_q),
    .kind     (t_kind),
    .addr     (t_addr),
    .data     (t_data)
  );

  nor_bus_cycle #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W),
    .SETUP_CLKS(SETUP_CLKS), .STROBE_CLKS(STROBE_CLKS), .HOLD_CLKS(HOLD_CLKS)
  ) u_bus (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (cyc_start),
    .rd        (cyc_rd),
    .addr      (cyc_addr),
    .wdata     (cyc_wdata),
    .bus_addr  (flash_addr),
    .bus_wdata (flash_wdata),
    .bus_rdata (flash_rdata),
    .we_n      (flash_we_n),
    .oe_n      (flash_oe_n),
    .rdata     (cyc_rdata),
    .cyc_done  (cyc_done)
  );

  always_comb begin
    cyc_start = 1'b0;
    cyc_rd    = 1'b1;
    cyc_addr  = poll_addr;
    cyc_wdata = '0;
    if (st_q == T_ISSUE && t_kind != K_END) begin
      cyc_start = 1'b1;
      cyc_rd    = (t_kind == K_READ);
      cyc_addr  = t_addr;
      cyc_wdata = t_data;
    end else if (st_q == T_PGO || st_q == T_RGO) begin
      cyc_start = 1'b1;
    end
  end

  always_comb begin
    st_d    = st_q;
    op_d    = op_q;
    addr_d  = addr_q;
    data_d  = data_q;
    wide_d  = wide_q;
    recov_d = recov_q;
    step_d  = step_q;
    pcnt_d  = pcnt_q;
    err_d   = err_q;
    id_d    = id_q;
    unique case (st_q)
      T_IDLE: begin
        if (req_valid && req_op <= OP_LAST) begin
          op_d    = op_e'(req_op);
          addr_d  = req_addr;
          data_d  = req_data;
          wide_d  = wide_bus;
          recov_d = 1'b0;
          step_d  = '0;
          pcnt_d  = '0;
          err_d   = RES_OK;
          st_d    = T_ISSUE;
        end
      end
      T_ISSUE: begin
        if (t_kind == K_END) begin
          if (recov_q || op_q == OP_RESET || op_q == OP_MFR_ID || op_q == OP_PART_ID)
            st_d = T_FIN;
          else
            st_d = T_PGO;
        end else begin
          st_d = T_WAIT;
        end
      end
      T_WAIT: begin
        if (cyc_done) begin
          if (t_kind == K_READ) id_d = cyc_rdata;
          step_d = step_q + 3'd1;
          st_d   = T_ISSUE;
        end
      end
      T_PGO: st_d = T_PWAIT;
      T_PWAIT: begin
        if (cyc_done) begin
          if (complete) begin
            st_d = T_FIN;
          end else if (op_q == OP_CHIP_ERASE && cyc_rdata[3]) begin
            err_d = RES_ERASE;
            st_d  = T_FIN;
          end else if (cyc_rdata[5]) begin
            st_d = T_RGO;
          end else if (pcnt_q == PCW'(MAX_POLLS - 1)) begin
            err_d = RES_TIMEOUT;
            st_d  = T_FIN;
          end else begin
            pcnt_d = pcnt_q + PCW'(1);
            st_d   = T_PGO;
          end
        end
      end
      T_RGO: st_d = T_RWAIT;
      T_RWAIT: begin
        if (cyc_done) begin
          if (complete) begin
            st_d = T_FIN;
          end else begin
            err_d   = (op_q == OP_PROGRAM) ? RES_WRITE : RES_ERASE;
            recov_d = 1'b1;
            step_d  = '0;
            st_d    = T_ISSUE;
          end
        end
      end
      T_FIN:   st_d = T_IDLE;
      default: st_d = T_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= T_IDLE;
      op_q    <= OP_RESET;
      addr_q  <= '0;
      data_q  <= '0;
      wide_q  <= 1'b0;
      recov_q <= 1'b0;
      step_q  <= '0;
      pcnt_q  <= '0;
      err_q   <= RES_OK;
      id_q    <= '0;
    end else begin
      st_q    <= st_d;
      op_q    <= op_d;
      addr_q  <= addr_d;
      data_q  <= data_d;
      wide_q  <= wide_d;
      recov_q <= recov_d;
      step_q  <= step_d;
      pcnt_q  <= pcnt_d;
      err_q   <= err_d;
      id_q    <= id_d;
    end
  end

  assign busy     = (st_q != T_IDLE);
  assign done     = (st_q == T_FIN);
  assign err_code = err_q;
  assign id_data  = id_q;

endmodule

// File: rtl/nor_cmd_sequencer_chk.sv
module nor_cmd_sequencer_chk #(
  parameter int ADDR_W = 20,
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic [2:0]        req_op,
  input logic              busy,
  input logic              done,
  input logic [ADDR_W-1:0] flash_addr,
  input logic [DATA_W-1:0] flash_wdata,
  input logic              flash_we_n,
  input logic              flash_oe_n
);

  assert_strobe_exclusive_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !(!flash_we_n && !flash_oe_n));

  assert_write_stable_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (!flash_we_n && !$past(flash_we_n)) |-> ($stable(flash_addr) && $stable(flash_wdata)));

  assert_read_stable_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (!flash_oe_n && !$past(flash_oe_n)) |-> $stable(flash_addr));

  assert_done_single_R12: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_done_in_busy_R12: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> busy);

  assert_busy_release_R12: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> $past(done));

  assert_accept_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && req_valid && req_op <= 3'd5) |=> busy);

  assert_quiet_idle_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (flash_we_n && flash_oe_n));

endmodule

bind nor_cmd_sequencer nor_cmd_sequencer_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .req_valid   (req_valid),
  .req_op      (req_op),
  .busy        (busy),
  .done        (done),
  .flash_addr  (flash_addr),
  .flash_wdata (flash_wdata),
  .flash_we_n  (flash_we_n),
  .flash_oe_n  (flash_oe_n)
);

// File: tb/nor_cmd_sequencer_test.sv
module nor_cmd_sequencer_test;

  localparam int CLK_PERIOD = 10;
  localparam int AW = 20;
  localparam int DW = 16;
  localparam int STROBE = 2;
  localparam int POLLS = 8;
  localparam logic [AW-1:0] WA1 = 20'h0AAAA, WA2 = 20'h15554;
  localparam logic [AW-1:0] NA1 = 20'h05555, NA2 = 20'h0AAAA;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wide_bus = 1'b1;
  logic req_valid = 1'b0;
  logic [2:0] req_op = '0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_data = '0;
  logic busy, done;
  logic [1:0] err_code;
  logic [DW-1:0] id_data;
  logic [AW-1:0] flash_addr;
  logic [DW-1:0] flash_wdata;
  logic [DW-1:0] flash_rdata = '0;
  logic flash_we_n, flash_oe_n;

  int checks = 0;
  int errors = 0;

  logic [AW-1:0] wa [0:31];
  logic [DW-1:0] wd [0:31];
  logic [AW-1:0] ra [0:31];
  logic [DW-1:0] stat [0:15];
  int nwr = 0, nrd = 0, nstat = 1;
  int slen = 0, bad_strobe = 0, both_low = 0;
  logic prev_we = 1'b1, prev_oe = 1'b1;
  logic [1:0] res;
  logic [DW-1:0] got_id;

  always #(CLK_PERIOD/2) clk = ~clk;

  nor_cmd_sequencer #(
    .ADDR_W(AW), .DATA_W(DW), .SETUP_CLKS(1), .STROBE_CLKS(STROBE),
    .HOLD_CLKS(1), .MAX_POLLS(POLLS)
  ) uut (
    .clk(clk), .rst_n(rst_n), .wide_bus(wide_bus), .req_valid(req_valid),
    .req_op(req_op), .req_addr(req_addr), .req_data(req_data), .busy(busy),
    .done(done), .err_code(err_code), .id_data(id_data), .flash_addr(flash_addr),
    .flash_wdata(flash_wdata), .flash_rdata(flash_rdata), .flash_we_n(flash_we_n),
    .flash_oe_n(flash_oe_n)
  );

  // behavioural device: logs writes, answers reads from a status script
  always @(negedge clk) begin
    if (!flash_we_n && prev_we) begin
      if (nwr < 32) begin wa[nwr] = flash_addr; wd[nwr] = flash_wdata; end
      nwr++;
    end
    if (!flash_oe_n && prev_oe) begin
      if (nrd < 32) ra[nrd] = flash_addr;
      flash_rdata = stat[(nrd < nstat) ? nrd : nstat - 1];
      nrd++;
    end
    if (!flash_we_n && !flash_oe_n) both_low++;
    if (!flash_we_n || !flash_oe_n) slen++;
    else if (slen != 0) begin
      if (slen != STROBE) bad_strobe++;
      slen = 0;
    end
    prev_we = flash_we_n;
    prev_oe = flash_oe_n;
  end

  task automatic check_eq(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic expect_w(input int i, input logic [AW-1:0] a, input logic [DW-1:0] d, input string tag);
    check_eq(tag, $sformatf("write %0d addr", i), 32'(wa[i]), 32'(a));
    check_eq(tag, $sformatf("write %0d data", i), 32'(wd[i]), 32'(d));
  endtask

  task automatic clear_log();
    nwr = 0;
    nrd = 0;
  endtask

  task automatic run_op(input logic [2:0] op, input logic [AW-1:0] a, input logic [DW-1:0] d);
    int n;
    @(negedge clk);
    req_op = op; req_addr = a; req_data = d; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    check_eq("R12", "busy after accept", 32'(busy), 32'd1);
    n = 0;
    while (!done && n < 2000) begin @(negedge clk); n++; end
    check_eq("R12", "done seen", 32'(done), 32'd1);
    res = err_code;
    got_id = id_data;
    @(negedge clk);
    check_eq("R12", "busy after done", 32'(busy), 32'd0);
  endtask

  task automatic t_reset_state();
    check_eq("R12", "reset busy", 32'(busy), 32'd0);
    check_eq("R12", "reset done", 32'(done), 32'd0);
    check_eq("R11", "reset strobes", 32'({flash_we_n, flash_oe_n}), 32'd3);
  endtask

  task automatic t_return_read();
    clear_log(); wide_bus = 1'b1; stat[0] = '0; nstat = 1;
    run_op(3'd0, '0, '0);
    check_eq("R5", "write count", 32'(nwr), 32'd3);
    check_eq("R5", "read count", 32'(nrd), 32'd0);
    expect_w(0, WA1, 16'h00AA, "R1");
    expect_w(1, WA2, 16'h0055, "R1");
    expect_w(2, WA1, 16'h00F0, "R5");
    check_eq("R5", "result", 32'(res), 32'd0);
  endtask

  task automatic t_ident(input logic [2:0] op, input logic [DW-1:0] idv, input logic [AW-1:0] radr, input logic w);
    clear_log(); wide_bus = w; stat[0] = idv; nstat = 1;
    run_op(op, '0, '0);
    check_eq("R6", "write count", 32'(nwr), 32'd6);
    check_eq("R6", "read count", 32'(nrd), 32'd1);
    check_eq("R6", "read addr", 32'(ra[0]), 32'(radr));
    expect_w(2, w ? WA1 : NA1, 16'h0090, "R6");
    expect_w(3, w ? WA1 : NA1, 16'h00AA, "R6");
    expect_w(5, w ? WA1 : NA1, 16'h00F0, "R6");
    check_eq("R6", "id value", 32'(got_id), 32'(idv));
    check_eq("R6", "result", 32'(res), 32'd0);
  endtask

  task automatic t_program_ok();
    clear_log(); wide_bus = 1'b1;
    stat[0] = 16'h0080; stat[1] = 16'h0080; stat[2] = 16'h1234; nstat = 3;
    run_op(3'd3, 20'h00400, 16'h1234);
    check_eq("R2", "write count", 32'(nwr), 32'd4);
    expect_w(2, WA1, 16'h00A0, "R2");
    expect_w(3, 20'h00400, 16'h1234, "R2");
    check_eq("R2", "poll count", 32'(nrd), 32'd3);
    check_eq("R2", "poll addr", 32'(ra[2]), 32'h400);
    check_eq("R2", "result", 32'(res), 32'd0);
  endtask

  task automatic t_program_recheck_ok();
    clear_log(); wide_bus = 1'b1;
    stat[0] = 16'h0020; stat[1] = 16'h00A0; nstat = 2;
    run_op(3'd3, 20'h00402, 16'h00FF);
    check_eq("R7", "reads", 32'(nrd), 32'd2);
    check_eq("R7", "writes", 32'(nwr), 32'd4);
    check_eq("R7", "result", 32'(res), 32'd0);
  endtask

  task automatic t_program_fail();
    clear_log(); wide_bus = 1'b1;
    stat[0] = 16'h0020; stat[1] = 16'h0020; nstat = 2;
    run_op(3'd3, 20'h00404, 16'h00FF);
    check_eq("R8", "reads", 32'(nrd), 32'd2);
    check_eq("R8", "writes", 32'(nwr), 32'd7);
    expect_w(4, WA1, 16'h00AA, "R8");
    expect_w(5, WA2, 16'h0055, "R8");
    expect_w(6, WA1, 16'h00F0, "R8");
    check_eq("R8", "result", 32'(res), 32'd1);
  endtask

  task automatic t_sector_ok();
    clear_log(); wide_bus = 1'b1;
    stat[0] = 16'h0000; stat[1] = 16'h0080; nstat = 2;
    run_op(3'd4, 20'h10000, '0);
    check_eq("R3", "writes", 32'(nwr), 32'd6);
    expect_w(2, WA1, 16'h0080, "R3");
    expect_w(3, WA1, 16'h00AA, "R3");
    expect_w(4, WA2, 16'h0055, "R3");
    expect_w(5, 20'h10000, 16'h0030, "R3");
    check_eq("R3", "reads", 32'(nrd), 32'd2);
    check_eq("R3", "poll addr", 32'(ra[1]), 32'h10000);
    check_eq("R3", "result", 32'(res), 32'd0);
  endtask

  task automatic t_sector_fail();
    clear_log(); wide_bus = 1'b1;
    stat[0] = 16'h0020; stat[1] = 16'h0000; nstat = 2;
    run_op(3'd4, 20'h20000, '0);
    check_eq("R8", "erase writes", 32'(nwr), 32'd9);
    expect_w(8, WA1, 16'h00F0, "R8");
    check_eq("R8", "erase result", 32'(res), 32'd2);
  endtask

  task automatic t_chip_ok();
    clear_log(); wide_bus = 1'b1;
    stat[0] = 16'h0000; stat[1] = 16'h0080; nstat = 2;
    run_op(3'd5, 20'h30000, '0);
    check_eq("R4", "writes", 32'(nwr), 32'd6);
    expect_w(5, WA1, 16'h0010, "R4");
    check_eq("R4", "poll addr", 32'(ra[0]), 32'h0);
    check_eq("R4", "reads", 32'(nrd), 32'd2);
    check_eq("R4", "result", 32'(res), 32'd0);
  endtask

  task automatic t_chip_dq3();
    clear_log(); wide_bus = 1'b1;
    stat[0] = 16'h0008; nstat = 1;
    run_op(3'd5, '0, '0);
    check_eq("R9", "writes", 32'(nwr), 32'd6);
    check_eq("R9", "reads", 32'(nrd), 32'd1);
    check_eq("R9", "result", 32'(res), 32'd2);
  endtask

  task automatic t_timeout();
    clear_log(); wide_bus = 1'b1;
    stat[0] = 16'h0080; nstat = 1;
    run_op(3'd3, 20'h00500, 16'h0001);
    check_eq("R10", "reads", 32'(nrd), 32'(POLLS));
    check_eq("R10", "writes", 32'(nwr), 32'd4);
    check_eq("R10", "result", 32'(res), 32'd3);
  endtask

  task automatic t_narrow();
    clear_log(); wide_bus = 1'b0; stat[0] = '0; nstat = 1;
    run_op(3'd0, '0, '0);
    expect_w(0, NA1, 16'h00AA, "R13");
    expect_w(1, NA2, 16'h0055, "R13");
    t_ident(3'd2, 16'h22DA, 20'h00001, 1'b0);
    wide_bus = 1'b1;
  endtask

  task automatic t_ignored();
    clear_log(); wide_bus = 1'b1; stat[0] = '0; nstat = 1;
    @(negedge clk);
    req_op = 3'd6; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    repeat (20) @(negedge clk);
    check_eq("R12", "op 6 busy", 32'(busy), 32'd0);
    check_eq("R12", "op 6 writes", 32'(nwr), 32'd0);
    req_op = 3'd0; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    repeat (3) @(negedge clk);
    req_op = 3'd3; req_addr = 20'h00100; req_data = 16'h0055; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    repeat (60) @(negedge clk);
    check_eq("R12", "busy request writes", 32'(nwr), 32'd3);
    check_eq("R12", "busy request reads", 32'(nrd), 32'd0);
    check_eq("R12", "idle at end", 32'(busy), 32'd0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset_state();
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_reset_state();
    t_return_read();
    t_ident(3'd1, 16'h00C2, 20'h00000, 1'b1);
    t_ident(3'd2, 16'h2249, 20'h00002, 1'b1);
    t_program_ok();
    t_program_recheck_ok();
    t_program_fail();
    t_sector_ok();
    t_sector_fail();
    t_chip_ok();
    t_chip_dq3();
    t_timeout();
    t_narrow();
    t_ignored();
    check_eq("R11", "strobe width errors", 32'(bad_strobe), 32'd0);
    check_eq("R11", "both strobes low", 32'(both_low), 32'd0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule